// File: doc/BRIEF.md
# Audio Clock Ratio Detector

This block runs on the master audio clock and watches the frame (left/right) clock. It counts how many master-clock cycles make up each full frame period and sorts the result into one of three ratios: 256, 384 or 512 master cycles per frame. It reports a lock only after two frame periods in a row give the same supported count. Once locked, it watches the frame clock for slips. A frame edge that comes early or does not come in time drops the lock, gives a single-cycle resync pulse, and starts detection again.

The block also picks the source of the serial bit clock. It counts transitions on the bit-clock input within each half of the frame period. If one half holds 15 or more transitions, the block moves to external mode and stays there until the next reset.

In internal mode, when locked, it makes its own bit clock from the master clock at exactly 64 bit periods per frame. This bit clock is realigned at every frame start. A per-bit strobe and a per-frame strobe serve as divider enables for the downstream filter and modulator stages.

Top module: `clk_ratio_detect`

## Requirements
- R1: While reset is held and just after it is released, locked_o, ext_mode_o, bclk_o, resync_o, bit_stb_o and frm_stb_o are 0 and ratio_o is 2'b11.
- R2: The period is measured from one frame-clock rising edge to the next, in master-clock cycles. A locked period of 256, 384 or 512 gives ratio_o = 2'b00, 2'b01 or 2'b10 respectively.
- R3: locked_o rises only at the third rising edge after reset or resync, that is, once two consecutive periods are equal and supported. A period matching no supported ratio keeps locked_o low. While unlocked, ratio_o is 2'b11.
- R4: While locked, a frame edge that arrives early, or one missing when the locked period expires, clears locked_o and sets ratio_o to 2'b11. A resync pulse is only issued from the locked state.
- R5: After a resync, the next frame-clock rising edge starts a new measurement. The block relocks at the third edge after the slip when two matching periods follow.
- R6: resync_o is high for exactly one master-clock cycle per slip.
- R7: 15 or more bit-clock transitions within one half of a frame period set ext_mode_o. 14 transitions in every half leave it clear.
- R8: ext_mode_o, once set, stays set until rst_ni is asserted.
- R9: In internal mode, while locked, bclk_o has a period of (locked period / 64) master cycles with a 50% duty cycle, giving 64 bit periods per frame. While unlocked or in external mode, bclk_o stays low.
- R10: While locked in internal mode, bit_stb_o pulses once per bit period (64 per frame) and frm_stb_o pulses once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master audio clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset / power-down |
| lrck_i | input | 1 | Frame clock, asynchronous |
| sclk_i | input | 1 | Bit-clock input, asynchronous |
| ratio_o | output | 2 | Detected ratio code: 00=256, 01=384, 10=512, 11=none |
| locked_o | output | 1 | Ratio detected and stable |
| ext_mode_o | output | 1 | External bit-clock mode selected (sticky) |
| bclk_o | output | 1 | Internally generated bit clock |
| resync_o | output | 1 | Single-cycle pulse on clock slip |
| bit_stb_o | output | 1 | Per-bit divider enable |
| frm_stb_o | output | 1 | Per-frame divider enable |

## Verification
The assertions assume that both asynchronous inputs are slow relative to the master clock: each level of the frame clock and of the bit-clock input must be held for at least two master cycles, so the two-flop synchronizers never drop an edge. The stimulus follows this rule in three ways. Every input change is applied on the falling master edge. Each frame half lasts at least 128 master cycles. Bit-clock toggles are spaced four master cycles apart and all fall inside a single frame half, so the transition counts seen by the block are exactly those the bench intends.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_256  = 2'b00,
    RATIO_384  = 2'b01,
    RATIO_512  = 2'b10,
    RATIO_NONE = 2'b11
  } ratio_e;

  localparam int unsigned LEN_256 = 256;
  localparam int unsigned LEN_384 = 384;
  localparam int unsigned LEN_512 = 512;

  function automatic ratio_e classify(input logic [15:0] len);
    if (len == 16'(LEN_256)) return RATIO_256;
    if (len == 16'(LEN_384)) return RATIO_384;
    if (len == 16'(LEN_512)) return RATIO_512;
    return RATIO_NONE;
  endfunction

endpackage

// File: rtl/ratio_sync2.sv
module ratio_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end

endmodule

// File: rtl/ratio_meas.sv
module ratio_meas
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           lr_rise_i,
  output logic           locked_o,
  output ratio_e         ratio_o,
  output logic [CNT_W:0] lock_len_o,
  output logic           resync_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   meas, prev_len_q, lock_len_q;
  logic             armed_q, prev_vld_q, locked_q, resync_q;
  ratio_e           ratio_q, meas_code;
  logic             slip;

  // period = cycles since last rise, including this one
  assign meas      = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign meas_code = classify(16'(meas));

  // early edge, or no edge when the locked period runs out
  assign slip = locked_q && ((lr_rise_i && meas != lock_len_q) ||
                             (!lr_rise_i && meas == lock_len_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      prev_len_q <= '0;
      lock_len_q <= '0;
      armed_q    <= 1'b0;
      prev_vld_q <= 1'b0;
      locked_q   <= 1'b0;
      resync_q   <= 1'b0;
      ratio_q    <= RATIO_NONE;
    end else begin
      resync_q <= 1'b0;
      if (lr_rise_i)          cnt_q <= '0;
      else if (cnt_q != '1)   cnt_q <= cnt_q + CNT_W'(1);

      if (slip) begin
        locked_q   <= 1'b0;
        ratio_q    <= RATIO_NONE;
        armed_q    <= 1'b0;
        prev_vld_q <= 1'b0;
        resync_q   <= 1'b1;
      end else if (lr_rise_i) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
        end else if (!locked_q) begin
          if (meas_code != RATIO_NONE && prev_vld_q && meas == prev_len_q) begin
            locked_q   <= 1'b1;
            ratio_q    <= meas_code;
            lock_len_q <= meas;
          end
          prev_len_q <= meas;
          prev_vld_q <= (meas_code != RATIO_NONE);
        end
      end
    end
  end

  assign locked_o   = locked_q;
  assign ratio_o    = ratio_q;
  assign lock_len_o = lock_len_q;
  assign resync_o   = resync_q;

  p_code_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |-> ratio_q == RATIO_NONE);

  p_lock_at_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(lr_rise_i));

  p_resync_from_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resync_q) |-> $past(locked_q));

  p_resync_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_q |=> !resync_q);

endmodule

// File: rtl/ratio_sclk_sense.sv
module ratio_sclk_sense #(
  parameter int THR = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lr_edge_i,
  input  logic tog_i,
  output logic ext_o
);

  localparam int TR_W = $clog2(THR + 1);

  logic [TR_W-1:0] tr_q;
  logic            ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tr_q  <= '0;
      ext_q <= 1'b0;
    end else begin
      if (lr_edge_i)                          tr_q <= {{(TR_W-1){1'b0}}, tog_i};
      else if (tog_i && tr_q != TR_W'(THR))   tr_q <= tr_q + TR_W'(1);
      // sticky until reset
      if (tr_q == TR_W'(THR)) ext_q <= 1'b1;
    end
  end

  assign ext_o = ext_q;

  p_ext_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |=> ext_q);

  p_ext_needs_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_q) |-> $past(tr_q) == TR_W'(THR));

endmodule

// File: rtl/ratio_bclk_gen.sv
module ratio_bclk_gen #(
  parameter int CNT_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           restart_i,
  input  logic [CNT_W:0] half_i,
  output logic           bclk_o,
  output logic           stb_o
);

  logic [CNT_W:0] div_q, nxt, last;
  logic           bclk_q, stb_q;

  assign last = (half_i << 1) - {{CNT_W{1'b0}}, 1'b1};
  assign nxt  = (restart_i || !run_i || div_q == last) ? '0 : div_q + (CNT_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      div_q  <= nxt;
      bclk_q <= run_i && (nxt < half_i);
      stb_q  <= run_i && (nxt == '0);
    end
  end

  assign bclk_o = bclk_q;
  assign stb_o  = stb_q;

  p_bclk_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !bclk_o && !stb_o);

  p_stb_on_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o && $past(run_i) |-> bclk_o);

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import clk_ratio_pkg::*;
#(
  parameter int CNT_W          = 10,
  parameter int BITS_PER_FRAME = 64,
  parameter int EXT_THR        = 15
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic       lrck_i,
  input  logic       sclk_i,
  output logic [1:0] ratio_o,
  output logic       locked_o,
  output logic       ext_mode_o,
  output logic       bclk_o,
  output logic       resync_o,
  output logic       bit_stb_o,
  output logic       frm_stb_o
);

  localparam int SHIFT = $clog2(2 * BITS_PER_FRAME);

  logic [1:0]     sync;
  logic           lr_q, sc_q;
  logic           lr_rise, lr_edge, sc_tog, sc_rise;
  logic           locked, ext_mode, int_stb, run;
  logic [CNT_W:0] lock_len, half_len;
  ratio_e         ratio;

  ratio_sync2 #(.WIDTH(2)) u_sync (
    .clk_i (mclk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, lrck_i}),
    .q_o   (sync)
  );

  always_ff @(posedge mclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q <= 1'b0;
      sc_q <= 1'b0;
    end else begin
      lr_q <= sync[0];
      sc_q <= sync[1];
    end
  end

  assign lr_rise = sync[0] & ~lr_q;
  assign lr_edge = sync[0] ^ lr_q;
  assign sc_tog  = sync[1] ^ sc_q;
  assign sc_rise = sync[1] & ~sc_q;

  ratio_meas #(.CNT_W(CNT_W)) u_meas (
    .clk_i     (mclk_i),
    .rst_ni    (rst_ni),
    .lr_rise_i (lr_rise),
    .locked_o  (locked),
    .ratio_o   (ratio),
    .lock_len_o(lock_len),
    .resync_o  (resync_o)
  );

  ratio_sclk_sense #(.THR(EXT_THR)) u_sense (
    .clk_i    (mclk_i),
    .rst_ni   (rst_ni),
    .lr_edge_i(lr_edge),
    .tog_i    (sc_tog),
    .ext_o    (ext_mode)
  );

  assign half_len = lock_len >> SHIFT;
  assign run      = locked && !ext_mode;

  ratio_bclk_gen #(.CNT_W(CNT_W)) u_bclk (
    .clk_i    (mclk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(lr_rise),
    .half_i   (half_len),
    .bclk_o   (bclk_o),
    .stb_o    (int_stb)
  );

  assign ratio_o    = ratio;
  assign locked_o   = locked;
  assign ext_mode_o = ext_mode;
  assign bit_stb_o  = ext_mode ? (locked && sc_rise) : int_stb;
  assign frm_stb_o  = locked && lr_rise;

endmodule

// File: tb/clk_ratio_detect_bench.sv
module clk_ratio_detect_bench;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic       sclk = 1'b0;
  logic [1:0] ratio;
  logic       locked, ext_mode, bclk, resync, bit_stb, frm_stb;

  int checks = 0, failures = 0, cyc = 0;
  int bclk_rises = 0, stb_cnt = 0, frm_cnt = 0, resync_cnt = 0;
  logic win_en = 1'b0, bclk_prev = 1'b0;

  always #2 mclk = ~mclk;

  clk_ratio_detect u_clk_ratio_detect (
    .mclk_i    (mclk),
    .rst_ni    (rst_n),
    .lrck_i    (lrck),
    .sclk_i    (sclk),
    .ratio_o   (ratio),
    .locked_o  (locked),
    .ext_mode_o(ext_mode),
    .bclk_o    (bclk),
    .resync_o  (resync),
    .bit_stb_o (bit_stb),
    .frm_stb_o (frm_stb)
  );

  always @(negedge mclk) begin
    if (win_en) begin
      if (bclk && !bclk_prev) bclk_rises++;
      if (bit_stb) stb_cnt++;
      if (frm_stb) frm_cnt++;
    end
    if (resync) resync_cnt++;
    bclk_prev = bclk;
  end

  always @(posedge mclk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge mclk);
    rst_n = 1'b0; lrck = 1'b0; sclk = 1'b0;
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;
    repeat (4) @(negedge mclk);
    resync_cnt = 0;
  endtask

  task automatic run_half(input int h, input logic lvl, input int tog);
    for (int c = 0; c < h; c++) begin
      @(negedge mclk);
      if (c == 0) lrck = lvl;
      if (c >= 2 && c < 2 + 4 * tog && (c - 2) % 4 == 0) sclk = ~sclk;
    end
  endtask

  task automatic run_frames(input int len, input int n, input int tog);
    for (int f = 0; f < n; f++) begin
      run_half(len / 2, 1'b1, tog);
      run_half(len / 2, 1'b0, tog);
    end
  endtask

  task automatic run_window(input int len, input int n, input int tog);
    @(posedge mclk);
    bclk_rises = 0; stb_cnt = 0; frm_cnt = 0;
    win_en = 1'b1;
    run_frames(len, n, tog);
    @(posedge mclk);
    win_en = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge mclk);
    rst_n = 1'b0;
    repeat (3) @(negedge mclk);
    check(!locked && !ext_mode && !bclk && !resync, "R1 flags in reset", {locked, ext_mode, bclk, resync}, 0);
    check(ratio == 2'b11, "R1 code in reset", ratio, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge mclk);
    check(!bit_stb && !frm_stb && !locked && ratio == 2'b11, "R1 after release", {bit_stb, frm_stb, locked}, 0);
  endtask

  task automatic t_lock(input int len, input int code);
    do_reset();
    run_frames(len, 2, 0);
    check(!locked, "R3 not locked after two edges", locked, 0);
    run_frames(len, 1, 0);
    check(locked, "R3 locked on third edge", locked, 1);
    check(ratio == code[1:0], "R2 ratio code", ratio, code);
    run_window(len, 4, 0);
    check(bclk_rises == 256, "R9 bclk 64 per frame", bclk_rises, 256);
    check(stb_cnt == 256, "R10 bit strobes", stb_cnt, 256);
    check(frm_cnt == 4, "R10 frame strobes", frm_cnt, 4);
    check(resync_cnt == 0, "R4 no resync when steady", resync_cnt, 0);
  endtask

  task automatic t_invalid();
    do_reset();
    run_window(300, 5, 0);
    check(!locked, "R3 unsupported period stays unlocked", locked, 0);
    check(ratio == 2'b11, "R3 code none while unlocked", ratio, 3);
    check(bclk_rises == 0, "R9 bclk idle unlocked", bclk_rises, 0);
  endtask

  task automatic t_slip_long();
    do_reset();
    run_frames(256, 3, 0);
    check(locked, "R2 lock before slip", locked, 1);
    run_frames(384, 1, 0);
    check(resync_cnt == 1, "R6 single resync cycle on missing edge", resync_cnt, 1);
    check(!locked && ratio == 2'b11, "R4 unlocked after missing edge", {locked, ratio}, 3);
    run_frames(384, 2, 0);
    check(!locked, "R5 restart needs fresh periods", locked, 0);
    run_frames(384, 1, 0);
    check(locked && ratio == 2'b01, "R5 relock at new ratio", ratio, 1);
    check(resync_cnt == 1, "R6 no extra resync", resync_cnt, 1);
  endtask

  task automatic t_slip_short();
    do_reset();
    run_frames(512, 3, 0);
    check(locked && ratio == 2'b10, "R2 lock 512", ratio, 2);
    run_frames(256, 1, 0);
    run_frames(512, 1, 0);
    check(resync_cnt == 1, "R6 resync on early edge", resync_cnt, 1);
    check(!locked && ratio == 2'b11, "R4 unlocked after early edge", {locked, ratio}, 3);
  endtask

  task automatic t_ext();
    do_reset();
    run_frames(256, 3, 15);
    check(ext_mode, "R7 ext mode on 15 transitions", ext_mode, 1);
    run_window(256, 2, 0);
    check(bclk_rises == 0, "R9 bclk idle in ext mode", bclk_rises, 0);
    check(ext_mode, "R8 ext mode sticky", ext_mode, 1);
    do_reset();
    check(!ext_mode, "R8 ext mode cleared by reset", ext_mode, 0);
  endtask

  task automatic t_below();
    do_reset();
    run_frames(256, 4, 14);
    check(!ext_mode, "R7 14 transitions stay internal", ext_mode, 0);
    check(locked, "R7 still locked internal", locked, 1);
  endtask

  initial begin
    t_reset_state();
    t_lock(256, 0);
    t_lock(384, 1);
    t_lock(512, 2);
    t_invalid();
    t_slip_long();
    t_slip_short();
    t_ext();
    t_below();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule